// File: doc/BRIEF.md
# Memory-Side Line Cache Controller

This block sits between a single line-wide request port and two memory ports: a small, fast near memory and a large far memory. Every request reads or writes one whole 64-byte line. A two-bit mode is captured while reset is held low, and it decides how the near memory is used. Near memory can be plain addressable storage, a direct-mapped cache for the whole far range, or a split of the two.

The near memory has no separate tag array. Each near line is wider than the data and holds a valid bit, a dirty bit and a tag next to the data. One near read therefore returns everything needed to decide hit or miss. On a miss that evicts a dirty line, the victim is written back to far memory before the new line is brought in. A write request always covers a full line, so a write miss installs the new data without reading far memory first.

The controller serves one request at a time. It drops its ready signal from the cycle it accepts a request until the cycle after the response pulse.

Top module: `memside_cache`

## Requirements
- R1: `mode_i` is sampled only while `rst_ni` is low. Encodings: 0 = flat, 1 = cache, 2 = hybrid with a quarter of near memory caching, 3 = hybrid with half of it caching. Changing `mode_i` after reset has no effect on address routing.
- R2: In flat mode, line address a < NEAR_LINES goes to near index a. Line address a ≥ NEAR_LINES goes to far line a − NEAR_LINES. No cache metadata is involved.
- R3: In cache mode, line address a (below FAR_LINES) is cached at near index a mod NEAR_LINES, with tag a / NEAR_LINES. A near line is laid out as {valid (MSB), dirty, tag (TAG_W bits), data (DATA_W LSBs)}.
- R4: A cached access always starts with exactly one near read. A read hit returns that line's data and makes no far-memory request.
- R5: A read miss on a clean or invalid line makes one far read. It then installs the line as valid=1, dirty=0 with the new tag, and returns the fetched data.
- R6: A miss on a valid dirty line first issues a far write of the victim data. The write goes to far line (victim tag × cache lines + index). The far read for the new line, if any, comes after this write.
- R7: A cached write, hit or miss, installs valid=1, dirty=1, the new tag and the written data. It makes no far read.
- R8: In the hybrid modes, the cache occupies near indices [0, C), with C = NEAR_LINES/4 for mode 2 and NEAR_LINES/2 for mode 3. Addresses a < NEAR_LINES − C map directly to near index C + a. Higher addresses are cached with far line a − (NEAR_LINES − C).
- R9: Writes to directly addressed near lines store all-zero metadata, so they are never installed as cache lines.
- R10: After reset, `req_ready_o` = 1 and `rsp_valid_o` = 0. `req_ready_o` is low from the cycle after acceptance until the response. `rsp_valid_o` is a single-cycle pulse.
- R11: A memory request holds its valid, address and direction stable until accepted. Near and far requests are never raised in the same cycle.
- R12: Every read returns the data most recently written to that line address, or the far memory's initial contents if the line was never written, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; mode is captured while low |
| mode_i | input | 2 | Operating mode, sampled in reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = line write, 0 = line read |
| req_addr_i | input | ADDR_W | Line address |
| req_wdata_i | input | DATA_W | Write line data |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Read line data, valid with the pulse for reads |
| nm_req_valid_o | output | 1 | Near memory request valid |
| nm_req_ready_i | input | 1 | Near memory accepts request |
| nm_req_write_o | output | 1 | Near memory write |
| nm_req_addr_o | output | NEAR_AW | Near line index |
| nm_req_wdata_o | output | NEAR_W | Near line with metadata |
| nm_rsp_valid_i | input | 1 | Near read data valid |
| nm_rsp_rdata_i | input | NEAR_W | Near read line with metadata |
| fm_req_valid_o | output | 1 | Far memory request valid |
| fm_req_ready_i | input | 1 | Far memory accepts request |
| fm_req_write_o | output | 1 | Far memory write |
| fm_req_addr_o | output | FAR_AW | Far line index |
| fm_req_wdata_o | output | DATA_W | Far write data |
| fm_rsp_valid_i | input | 1 | Far read data valid |
| fm_rsp_rdata_i | input | DATA_W | Far read data |

## Verification
The properties assume the following about the block's inputs:
- Request addresses stay inside the address space of the latched mode.
- Each memory returns exactly one response per accepted read and none for writes.
- The near array starts with every valid bit clear.

The bench keeps to these assumptions in three ways:
- It draws addresses only from the flat span and the cached span of the current mode.
- Its behavioural memories answer each read once after a fixed delay.
- It clears the near array, and reloads the far array with a known pattern, on every reset.

Ready stalls on both memories come from a pseudo-random sequence, so the hold properties are exercised under back-pressure.

// File: rtl/msc_pkg.sv
package msc_pkg;
  typedef enum logic [1:0] {
    MODE_FLAT     = 2'd0,
    MODE_CACHE    = 2'd1,
    MODE_HYB_QTR  = 2'd2,
    MODE_HYB_HALF = 2'd3
  } mode_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_N_RD,
    S_N_RDW,
    S_F_WR,
    S_F_RD,
    S_F_RDW,
    S_N_WR,
    S_RSP
  } state_t;
endpackage

// File: rtl/msc_mode_latch.sv
module msc_mode_latch
  import msc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  output mode_t      mode_o
);
  mode_t mode_q;

  // loads only while reset is asserted; holds afterwards
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= mode_t'(mode_i);
    else         mode_q <= mode_q;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/msc_addr_map.sv
module msc_addr_map
  import msc_pkg::*;
#(
  parameter int NEAR_LINES = 64,
  parameter int FAR_LINES  = 256,
  localparam int NEAR_AW = $clog2(NEAR_LINES),
  localparam int FAR_AW  = $clog2(FAR_LINES),
  localparam int ADDR_W  = $clog2(NEAR_LINES + FAR_LINES),
  localparam int TAG_W   = FAR_AW - NEAR_AW + 2,
  localparam int LO      = NEAR_AW - 2
) (
  input  mode_t               mode_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                to_near_o,
  output logic                cached_o,
  output logic [NEAR_AW-1:0]  near_idx_o,
  output logic [FAR_AW-1:0]   far_addr_o,
  output logic [TAG_W-1:0]    tag_o,
  output logic [1:0]          grow_o,
  output logic [ADDR_W:0]     cache_lines_o
);
  logic [ADDR_W:0] flat_near;
  logic [ADDR_W:0] a_ext;

  // grow: extra index bits above the quarter-size cache
  always_comb begin
    unique case (mode_i)
      MODE_CACHE:    grow_o = 2'd2;
      MODE_HYB_HALF: grow_o = 2'd1;
      default:       grow_o = 2'd0;
    endcase
  end

  always_comb begin
    a_ext         = {1'b0, addr_i};
    cache_lines_o = (mode_i == MODE_FLAT) ? '0
                  : ((ADDR_W+1)'(1) << (LO + int'(grow_o)));
    flat_near     = (ADDR_W+1)'(NEAR_LINES) - cache_lines_o;
    to_near_o     = a_ext < flat_near;
    cached_o      = !to_near_o && (mode_i != MODE_FLAT);
    far_addr_o    = FAR_AW'(a_ext - flat_near);
    tag_o         = TAG_W'(far_addr_o[FAR_AW-1:LO] >> grow_o);
    if (to_near_o) near_idx_o = NEAR_AW'(a_ext + cache_lines_o);
    else           near_idx_o = NEAR_AW'(far_addr_o & FAR_AW'(cache_lines_o - 1'b1));
  end
endmodule

// File: rtl/msc_tag_check.sv
module msc_tag_check #(
  parameter int NEAR_LINES = 64,
  parameter int FAR_LINES  = 256,
  parameter int DATA_W     = 512,
  localparam int NEAR_AW = $clog2(NEAR_LINES),
  localparam int FAR_AW  = $clog2(FAR_LINES),
  localparam int TAG_W   = FAR_AW - NEAR_AW + 2,
  localparam int NEAR_W  = DATA_W + TAG_W + 2,
  localparam int LO      = NEAR_AW - 2
) (
  input  logic [NEAR_W-1:0]  line_i,
  input  logic [TAG_W-1:0]   tag_i,
  input  logic [NEAR_AW-1:0] idx_i,
  input  logic [1:0]         grow_i,
  output logic               hit_o,
  output logic               dirty_o,
  output logic [FAR_AW-1:0]  victim_addr_o,
  output logic [DATA_W-1:0]  data_o
);
  logic             v;
  logic             d;
  logic [TAG_W-1:0] t;

  assign v       = line_i[NEAR_W-1];
  assign d       = line_i[NEAR_W-2];
  assign t       = line_i[DATA_W +: TAG_W];
  assign data_o  = line_i[DATA_W-1:0];
  assign hit_o   = v && (t == tag_i);
  assign dirty_o = v && d;
  assign victim_addr_o = (FAR_AW'(t) << (LO + int'(grow_i))) | FAR_AW'(idx_i);
endmodule

// File: rtl/memside_cache.sv
module memside_cache
  import msc_pkg::*;
#(
  parameter int NEAR_LINES = 64,
  parameter int FAR_LINES  = 256,
  parameter int LINE_BYTES = 64,
  localparam int DATA_W  = LINE_BYTES * 8,
  localparam int NEAR_AW = $clog2(NEAR_LINES),
  localparam int FAR_AW  = $clog2(FAR_LINES),
  localparam int ADDR_W  = $clog2(NEAR_LINES + FAR_LINES),
  localparam int TAG_W   = FAR_AW - NEAR_AW + 2,
  localparam int NEAR_W  = DATA_W + TAG_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic               nm_req_valid_o,
  input  logic               nm_req_ready_i,
  output logic               nm_req_write_o,
  output logic [NEAR_AW-1:0] nm_req_addr_o,
  output logic [NEAR_W-1:0]  nm_req_wdata_o,
  input  logic               nm_rsp_valid_i,
  input  logic [NEAR_W-1:0]  nm_rsp_rdata_i,
  output logic               fm_req_valid_o,
  input  logic               fm_req_ready_i,
  output logic               fm_req_write_o,
  output logic [FAR_AW-1:0]  fm_req_addr_o,
  output logic [DATA_W-1:0]  fm_req_wdata_o,
  input  logic               fm_rsp_valid_i,
  input  logic [DATA_W-1:0]  fm_rsp_rdata_i
);
  mode_t              mode;
  logic               map_to_near, map_cached;
  logic [NEAR_AW-1:0] map_near_idx;
  logic [FAR_AW-1:0]  map_far_addr;
  logic [TAG_W-1:0]   map_tag;
  logic [1:0]         grow;
  logic [ADDR_W:0]    cache_lines;

  logic               tc_hit, tc_dirty;
  logic [FAR_AW-1:0]  tc_victim;
  logic [DATA_W-1:0]  tc_data;

  state_t             st_q;
  logic               wr_q, cached_q, victim_q;
  logic [NEAR_AW-1:0] near_idx_q;
  logic [FAR_AW-1:0]  far_addr_q, victim_addr_q;
  logic [TAG_W-1:0]   tag_q;
  logic [DATA_W-1:0]  wdata_q, line_q;

  msc_mode_latch u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .mode_o (mode)
  );

  msc_addr_map #(.NEAR_LINES(NEAR_LINES), .FAR_LINES(FAR_LINES)) u_map (
    .mode_i        (mode),
    .addr_i        (req_addr_i),
    .to_near_o     (map_to_near),
    .cached_o      (map_cached),
    .near_idx_o    (map_near_idx),
    .far_addr_o    (map_far_addr),
    .tag_o         (map_tag),
    .grow_o        (grow),
    .cache_lines_o (cache_lines)
  );

  msc_tag_check #(.NEAR_LINES(NEAR_LINES), .FAR_LINES(FAR_LINES), .DATA_W(DATA_W)) u_tag (
    .line_i        (nm_rsp_rdata_i),
    .tag_i         (tag_q),
    .idx_i         (near_idx_q),
    .grow_i        (grow),
    .hit_o         (tc_hit),
    .dirty_o       (tc_dirty),
    .victim_addr_o (tc_victim),
    .data_o        (tc_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= S_IDLE;
      wr_q          <= 1'b0;
      cached_q      <= 1'b0;
      victim_q      <= 1'b0;
      near_idx_q    <= '0;
      far_addr_q    <= '0;
      victim_addr_q <= '0;
      tag_q         <= '0;
      wdata_q       <= '0;
      line_q        <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          wr_q       <= req_write_i;
          cached_q   <= map_cached;
          victim_q   <= 1'b0;
          near_idx_q <= map_near_idx;
          far_addr_q <= map_far_addr;
          tag_q      <= map_tag;
          wdata_q    <= req_wdata_i;
          if (map_to_near)     st_q <= req_write_i ? S_N_WR : S_N_RD;
          else if (map_cached) st_q <= S_N_RD;
          else                 st_q <= req_write_i ? S_F_WR : S_F_RD;
        end
        S_N_RD: if (nm_req_ready_i) st_q <= S_N_RDW;
        S_N_RDW: if (nm_rsp_valid_i) begin
          line_q <= tc_data;
          if (!cached_q)   st_q <= S_RSP;
          else if (tc_hit) st_q <= wr_q ? S_N_WR : S_RSP;
          else if (tc_dirty) begin
            victim_q      <= 1'b1;
            victim_addr_q <= tc_victim;
            st_q          <= S_F_WR;
          end else st_q <= wr_q ? S_N_WR : S_F_RD;
        end
        S_F_WR: if (fm_req_ready_i) begin
          if (victim_q) begin
            victim_q <= 1'b0;
            st_q     <= wr_q ? S_N_WR : S_F_RD;
          end else st_q <= S_RSP;
        end
        S_F_RD: if (fm_req_ready_i) st_q <= S_F_RDW;
        S_F_RDW: if (fm_rsp_valid_i) begin
          line_q <= fm_rsp_rdata_i;
          st_q   <= cached_q ? S_N_WR : S_RSP;
        end
        S_N_WR: if (nm_req_ready_i) st_q <= S_RSP;
        S_RSP: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (st_q == S_IDLE);
  assign rsp_valid_o    = (st_q == S_RSP);
  assign rsp_rdata_o    = line_q;

  assign nm_req_valid_o = (st_q == S_N_RD) || (st_q == S_N_WR);
  assign nm_req_write_o = (st_q == S_N_WR);
  assign nm_req_addr_o  = near_idx_q;
  assign nm_req_wdata_o = cached_q ? {1'b1, wr_q, tag_q, (wr_q ? wdata_q : line_q)}
                                   : {2'b00, {TAG_W{1'b0}}, wdata_q};

  assign fm_req_valid_o = (st_q == S_F_WR) || (st_q == S_F_RD);
  assign fm_req_write_o = (st_q == S_F_WR);
  assign fm_req_addr_o  = victim_q ? victim_addr_q : far_addr_q;
  assign fm_req_wdata_o = victim_q ? line_q : wdata_q;

  // R10
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R10
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));

  // R11
  excl_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nm_req_valid_o && fm_req_valid_o));

  // R11
  nm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nm_req_valid_o && !nm_req_ready_i) |=>
      (nm_req_valid_o && $stable(nm_req_addr_o) && $stable(nm_req_write_o)));

  // R11
  fm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fm_req_valid_o && !fm_req_ready_i) |=>
      (fm_req_valid_o && $stable(fm_req_addr_o) && $stable(fm_req_write_o)));

  // R9
  no_flat_install_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nm_req_valid_o && nm_req_write_o && nm_req_wdata_o[NEAR_W-1]) |->
      ((ADDR_W+1)'(nm_req_addr_o) < cache_lines));
endmodule

// File: tb/memside_cache_test.sv
`timescale 1ns/1ps
module memside_cache_test;
  localparam int NEAR_LINES = 64;
  localparam int FAR_LINES  = 256;
  localparam int DATA_W  = 512;
  localparam int NEAR_AW = 6;
  localparam int FAR_AW  = 8;
  localparam int ADDR_W  = 9;
  localparam int TAG_W   = 4;
  localparam int NEAR_W  = DATA_W + TAG_W + 2;
  localparam int SPACE   = NEAR_LINES + FAR_LINES;

  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic [1:0]         mode;
  logic               req_valid = 0, req_write = 0;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic [DATA_W-1:0]  req_wdata = '0;
  logic               req_ready, rsp_valid;
  logic [DATA_W-1:0]  rsp_rdata;
  logic               nm_valid, nm_write, nm_rvalid;
  logic [NEAR_AW-1:0] nm_addr;
  logic [NEAR_W-1:0]  nm_wdata, nm_rdata;
  logic               fm_valid, fm_write, fm_rvalid;
  logic [FAR_AW-1:0]  fm_addr;
  logic [DATA_W-1:0]  fm_wdata, fm_rdata;
  logic               nm_ready, fm_ready;

  memside_cache uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .nm_req_valid_o(nm_valid), .nm_req_ready_i(nm_ready), .nm_req_write_o(nm_write),
    .nm_req_addr_o(nm_addr), .nm_req_wdata_o(nm_wdata),
    .nm_rsp_valid_i(nm_rvalid), .nm_rsp_rdata_i(nm_rdata),
    .fm_req_valid_o(fm_valid), .fm_req_ready_i(fm_ready), .fm_req_write_o(fm_write),
    .fm_req_addr_o(fm_addr), .fm_req_wdata_o(fm_wdata),
    .fm_rsp_valid_i(fm_rvalid), .fm_rsp_rdata_i(fm_rdata)
  );

  int tests = 0, fails = 0;

  function automatic logic [DATA_W-1:0] pat(int f, int s);
    logic [31:0] w;
    w = (32'(f) * 32'h9E37) ^ (32'(s) << 20) ^ 32'hC0DE0000;
    return {(DATA_W/32){w}};
  endfunction

  // behavioural memories
  logic [NEAR_W-1:0]  nmem [NEAR_LINES];
  logic [DATA_W-1:0]  fmem [FAR_LINES];
  logic [15:0] lfsr = 16'hACE1;
  logic clr = 0;
  int n_pend = 0, f_pend = 0;
  logic [NEAR_AW-1:0] n_paddr;
  logic [FAR_AW-1:0]  f_paddr;
  int nm_rd_cnt = 0, fm_rd_cnt = 0, fm_wr_cnt = 0, overlap = 0;
  logic [7:0] fops = '0;

  assign nm_ready = lfsr[0] | lfsr[3];
  assign fm_ready = lfsr[1] | lfsr[5];

  always @(posedge clk) begin
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    nm_rvalid <= 1'b0;
    fm_rvalid <= 1'b0;
    if (clr) begin
      for (int i = 0; i < NEAR_LINES; i++) nmem[i] <= '0;
      for (int i = 0; i < FAR_LINES; i++)  fmem[i] <= pat(i, 0);
      n_pend <= 0; f_pend <= 0;
      nm_rd_cnt <= 0; fm_rd_cnt <= 0; fm_wr_cnt <= 0; overlap <= 0; fops <= '0;
    end else begin
      if (nm_valid && fm_valid) overlap <= overlap + 1;
      if (n_pend > 0) begin
        n_pend <= n_pend - 1;
        if (n_pend == 1) begin nm_rvalid <= 1'b1; nm_rdata <= nmem[n_paddr]; end
      end
      if (f_pend > 0) begin
        f_pend <= f_pend - 1;
        if (f_pend == 1) begin fm_rvalid <= 1'b1; fm_rdata <= fmem[f_paddr]; end
      end
      if (nm_valid && nm_ready) begin
        if (nm_write) nmem[nm_addr] <= nm_wdata;
        else begin n_pend <= 2; n_paddr <= nm_addr; nm_rd_cnt <= nm_rd_cnt + 1; end
      end
      if (fm_valid && fm_ready) begin
        fops <= {fops[5:0], fm_write ? 2'd2 : 2'd1};
        if (fm_write) begin fmem[fm_addr] <= fm_wdata; fm_wr_cnt <= fm_wr_cnt + 1; end
        else begin f_pend <= 3; f_paddr <= fm_addr; fm_rd_cnt <= fm_rd_cnt + 1; end
      end
    end
  end

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { bit rd; logic [DATA_W-1:0] d; int addr; } exp_t;
  exp_t sbq[$];
  logic [DATA_W-1:0] refm [SPACE];
  int issued = 0, rsp_cnt = 0;
  int cl = 0, fn = 0;

  always @(negedge clk) begin
    if (rsp_valid) begin
      if (sbq.size() == 0) chk(0, "R10", "unexpected response", 1, 0);
      else begin
        exp_t e;
        e = sbq.pop_front();
        if (e.rd) chk(rsp_rdata == e.d, "R12", $sformatf("read data @%0d", e.addr),
                      longint'(rsp_rdata[63:0]), longint'(e.d[63:0]));
      end
      rsp_cnt++;
    end
  end

  task automatic do_req(bit wr, int a, logic [DATA_W-1:0] d);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = ADDR_W'(a); req_wdata = d;
    e.rd = !wr; e.d = wr ? d : refm[a]; e.addr = a;
    if (wr) refm[a] = d;
    sbq.push_back(e);
    issued++;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R10", "ready low after accept", req_ready, 0);
    while (rsp_cnt != issued) @(negedge clk);
  endtask

  task automatic phase(int m);
    rst_n = 0; mode = 2'(m); clr = 1;
    unique case (m)
      0: begin cl = 0;  fn = 64; end
      1: begin cl = 64; fn = 0;  end
      2: begin cl = 16; fn = 48; end
      default: begin cl = 32; fn = 32; end
    endcase
    for (int i = 0; i < SPACE; i++) refm[i] = (i < fn) ? '0 : pat(i - fn, 0);
    repeat (3) @(negedge clk);
    clr = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R10", "no rsp after reset", rsp_valid, 0);
  endtask

  task automatic rnd(int n, int ph);
    for (int k = 0; k < n; k++) begin
      int a, f;
      bit wr;
      if (fn > 0 && ($urandom % 3 == 0)) a = $urandom % fn;
      else begin
        if (cl > 0) f = ($urandom % 4) + cl * ($urandom % 4);
        else        f = $urandom % FAR_LINES;
        a = fn + f;
      end
      wr = 1'($urandom % 2);
      do_req(wr, a, pat(a, k + 1000 * ph + 1));
    end
  endtask

  function automatic logic [TAG_W+1:0] meta(int i);
    return nmem[i][NEAR_W-1:DATA_W];
  endfunction

  initial begin
    int snap_fr, snap_fw, snap_nr;
    logic [DATA_W-1:0] w;
    mode = 2'd0;

    // flat mode
    phase(0);
    w = pat(5, 77);
    do_req(1, 5, w);
    chk(nmem[5][DATA_W-1:0] == w, "R2", "flat near write index", longint'(nmem[5][63:0]), longint'(w[63:0]));
    chk(meta(5) == '0, "R9", "flat near meta zero", meta(5), 0);
    do_req(0, 5, '0);
    w = pat(74, 78);
    do_req(1, 74, w);
    chk(fmem[10] == w, "R2", "flat far line a-64", longint'(fmem[10][63:0]), longint'(w[63:0]));
    do_req(0, 74, '0);
    rnd(120, 1);

    // cache mode; mode_i changed after reset must be ignored
    phase(1);
    mode = 2'd0;
    snap_fr = fm_rd_cnt;
    do_req(0, 70, '0);
    chk(fm_rd_cnt == snap_fr + 1, "R1", "mode held as cache after input change", fm_rd_cnt - snap_fr, 1);
    snap_fr = fm_rd_cnt; snap_fw = fm_wr_cnt;
    do_req(0, 3, '0);
    chk(fm_rd_cnt == snap_fr + 1 && fm_wr_cnt == snap_fw, "R5", "clean miss one far read", fm_rd_cnt - snap_fr, 1);
    chk(meta(3) == {1'b1, 1'b0, 4'd0}, "R3", "installed meta v=1 d=0 tag0", meta(3), 6'b100000);
    snap_fr = fm_rd_cnt; snap_nr = nm_rd_cnt;
    do_req(0, 3, '0);
    chk(fm_rd_cnt == snap_fr, "R4", "hit makes no far read", fm_rd_cnt - snap_fr, 0);
    chk(nm_rd_cnt == snap_nr + 1, "R4", "hit one near read", nm_rd_cnt - snap_nr, 1);
    w = pat(67, 99);
    snap_fr = fm_rd_cnt; snap_fw = fm_wr_cnt;
    do_req(1, 67, w);
    chk(fm_rd_cnt == snap_fr && fm_wr_cnt == snap_fw, "R7", "write miss no far traffic", fm_rd_cnt - snap_fr, 0);
    chk(meta(3) == {1'b1, 1'b1, 4'd1}, "R7", "write install v=1 d=1 tag1", meta(3), 6'b110001);
    chk(nmem[3][DATA_W-1:0] == w, "R7", "write install data", longint'(nmem[3][63:0]), longint'(w[63:0]));
    do_req(0, 3, '0);
    chk(fmem[67] == w, "R6", "victim written back to tag*64+set", longint'(fmem[67][63:0]), longint'(w[63:0]));
    chk(fops[3:0] == 4'b1001, "R6", "write-back before fetch", fops[3:0], 4'b1001);
    do_req(0, 67, '0);
    rnd(150, 2);

    // hybrid quarter: cache 16 lines, flat near 48
    phase(2);
    w = pat(10, 55);
    snap_fw = fm_wr_cnt;
    do_req(1, 10, w);
    chk(nmem[26][DATA_W-1:0] == w, "R8", "hybrid flat near index C+a", longint'(nmem[26][63:0]), longint'(w[63:0]));
    chk(meta(26) == '0 && fm_wr_cnt == snap_fw, "R9", "hybrid flat line not installed", meta(26), 0);
    w = pat(53, 56);
    do_req(1, 53, w);
    chk(meta(5) == {1'b1, 1'b1, 4'd0}, "R8", "hybrid cached set 5 tag0", meta(5), 6'b110000);
    do_req(0, 69, '0);
    chk(fmem[5] == w, "R6", "hybrid victim to far 5", longint'(fmem[5][63:0]), longint'(w[63:0]));
    chk(meta(5) == {1'b1, 1'b0, 4'd1}, "R5", "hybrid fill tag1 clean", meta(5), 6'b100001);
    rnd(150, 3);

    // hybrid half: cache 32 lines, flat near 32
    phase(3);
    w = pat(31, 57);
    do_req(1, 31, w);
    chk(nmem[63][DATA_W-1:0] == w && meta(63) == '0, "R8", "hybrid half flat near 63",
        longint'(nmem[63][63:0]), longint'(w[63:0]));
    do_req(0, 32, '0);
    chk(meta(0) == {1'b1, 1'b0, 4'd0}, "R8", "hybrid half far0 at set0", meta(0), 6'b100000);
    do_req(0, 64, '0);
    chk(meta(0) == {1'b1, 1'b0, 4'd1}, "R8", "hybrid half far32 tag1", meta(0), 6'b100001);
    rnd(150, 4);

    chk(overlap == 0, "R11", "near and far never both requested", overlap, 0);
    chk(sbq.size() == 0, "R12", "all responses seen", sbq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule